// File: doc/BRIEF.md
# Pipelined Three-by-Three Coefficient Matrix Multiplier

This block multiplies a three-element sample vector by a programmable 3x3 matrix of signed coefficients. It accepts a new vector on every clock cycle and emits three results per vector, one for each matrix row. A typical use is color-space conversion in a video datapath: the three channels of a pixel enter on the A, B and C data ports, and the converted channels leave on X, Y and Z.

The matrix is loaded one row at a time. The row-select code is two bits wide. The value zero leaves every coefficient unchanged. A non-zero value loads the three coefficient words currently on the coefficient inputs into the row named by the code. Each output is the full-precision signed sum of three products. That sum is rounded by adding half of the weight of the lowest kept bit and shifting right by a parameterised number of bits, and it is then clamped into the 12-bit signed range. The datapath has no reset, so outputs are meaningful only while the valid flag that travels beside them is high.

Top module: `tridot_matrix`

## Requirements
- R1: A synchronous active-high reset clears every coefficient to zero and clears all valid flags, so `out_valid` is low after reset and a sample presented after reset produces zero on all three outputs.
- R2: While `kw_code` is 2'b00 no coefficient changes, whatever the coefficient inputs carry. A row that the code does not select also keeps its value.
- R3: `kw_code` 2'b01 loads `k_a_in`, `k_b_in` and `k_c_in` into the row that feeds X. Code 2'b10 loads them into the row that feeds Y, and code 2'b11 into the row that feeds Z. Within a row, `k_a_in` weights A, `k_b_in` weights B and `k_c_in` weights C.
- R4: Data and coefficients are two's-complement signed values. Each output is A·Ka + B·Kb + C·Kc over its own row, and this sum is kept at full precision before rounding.
- R5: Rounding adds 2^(SHIFT-1) to the full sum and then shifts it arithmetically right by SHIFT bits (SHIFT defaults to 8). Ties therefore round toward plus infinity: 1.5 gives 2 and -1.5 gives -1.
- R6: A rounded value above 2047 is output as 2047, and a value below -2048 is output as -2048.
- R7: The results for a sample appear on the outputs exactly five clock cycles after the sample is presented. `out_valid` follows `in_valid` with the same five-cycle delay.
- R8: Samples presented on consecutive cycles produce results on consecutive cycles, one triplet per cycle, with no bubbles.
- R9: A sample presented in the same cycle as a coefficient write uses the coefficients from before the write. The sample presented one cycle later uses the new ones. Samples already in the pipeline are not affected by the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the A/B/C sample of this cycle as valid |
| a_in | input | 12 | Signed sample, first vector element |
| b_in | input | 12 | Signed sample, second vector element |
| c_in | input | 12 | Signed sample, third vector element |
| k_a_in | input | 10 | Signed coefficient that weights A in the row being loaded |
| k_b_in | input | 10 | Signed coefficient that weights B in the row being loaded |
| k_c_in | input | 10 | Signed coefficient that weights C in the row being loaded |
| kw_code | input | 2 | Row load code: 00 hold, 01 X row, 10 Y row, 11 Z row |
| out_valid | output | 1 | Outputs carry the result of a valid sample |
| x_out | output | 12 | Signed rounded and clamped result of the first row |
| y_out | output | 12 | Signed rounded and clamped result of the second row |
| z_out | output | 12 | Signed rounded and clamped result of the third row |

## Verification
The hardest case to reach from the ports is a coefficient write that lands in the middle of a stream. One sample must already be in flight, one must arrive in the same cycle as the write, and one must follow it, so that three different coefficient views are compared at the outputs. The stimulus builds this case by issuing the row write on the cycle between two back-to-back samples. The expected results come from a model whose matrix is updated only after the write cycle. Saturation is reached with full-scale coefficients and extreme inputs of both signs. The exact rounding ties come from a coefficient of one half applied to odd inputs.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic [1:0] {
    KW_HOLD  = 2'b00,
    KW_ROW_X = 2'b01,
    KW_ROW_Y = 2'b10,
    KW_ROW_Z = 2'b11
  } kw_code_e;

  // register stages between the input ports and the output registers
  localparam int PIPE_STAGES = 5;
  localparam int MAT_ROWS    = 3;
  localparam int MAT_COLS    = 3;

endpackage

// File: rtl/tdm_coef_bank.sv
module tdm_coef_bank #(
  parameter int COEF_W = 10
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [1:0]                                      kw_code,
  input  logic [COEF_W-1:0]                               k_a,
  input  logic [COEF_W-1:0]                               k_b,
  input  logic [COEF_W-1:0]                               k_c,
  output logic [tdm_pkg::MAT_ROWS*tdm_pkg::MAT_COLS*COEF_W-1:0] k_flat
);
  localparam int ROW_W = tdm_pkg::MAT_COLS * COEF_W;

  for (genvar r = 0; r < tdm_pkg::MAT_ROWS; r++) begin : g_row
    localparam logic [1:0] SEL = 2'(r + 1);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (kw_code == SEL) begin
        row_q <= {k_a, k_b, k_c};
      end
    end

    assign k_flat[r*ROW_W +: ROW_W] = row_q;
  end

endmodule

// File: rtl/tdm_round_clamp.sv
module tdm_round_clamp #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 12,
  parameter int SHIFT = 8
) (
  input  logic                    clk,
  input  logic signed [IN_W-1:0]  sum_in,
  output logic signed [OUT_W-1:0] y
);
  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (SHIFT - 1);
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] rnd_q;

  assign biased = EXT_W'(sum_in) + HALF;

  // stage 4: round half up
  always_ff @(posedge clk) begin
    rnd_q <= biased >>> SHIFT;
  end

  // stage 5: clamp into output range
  always_ff @(posedge clk) begin
    if (rnd_q > MAXV) begin
      y <= MAXV[OUT_W-1:0];
    end else if (rnd_q < MINV) begin
      y <= MINV[OUT_W-1:0];
    end else begin
      y <= rnd_q[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/tdm_dot_lane.sv
module tdm_dot_lane #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 8
) (
  input  logic                     clk,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  input  logic signed [DATA_W-1:0] c,
  input  logic signed [COEF_W-1:0] ka,
  input  logic signed [COEF_W-1:0] kb,
  input  logic signed [COEF_W-1:0] kc,
  output logic signed [OUT_W-1:0]  y
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int PAIR_W = PROD_W + 1;
  localparam int SUM_W  = PROD_W + 2;

  logic signed [PROD_W-1:0] pa_q, pb_q, pc_q;
  logic signed [PAIR_W-1:0] pab_q;
  logic signed [PROD_W-1:0] pc_d_q;
  logic signed [SUM_W-1:0]  sum_q;

  // stage 1: products against the coefficients current at the latch edge
  always_ff @(posedge clk) begin
    pa_q <= PROD_W'(a) * PROD_W'(ka);
    pb_q <= PROD_W'(b) * PROD_W'(kb);
    pc_q <= PROD_W'(c) * PROD_W'(kc);
  end

  // stage 2: first adder level
  always_ff @(posedge clk) begin
    pab_q  <= PAIR_W'(pa_q) + PAIR_W'(pb_q);
    pc_d_q <= pc_q;
  end

  // stage 3: full-precision three-term sum
  always_ff @(posedge clk) begin
    sum_q <= SUM_W'(pab_q) + SUM_W'(pc_d_q);
  end

  tdm_round_clamp #(
    .IN_W (SUM_W),
    .OUT_W(OUT_W),
    .SHIFT(SHIFT)
  ) u_rc (
    .clk   (clk),
    .sum_in(sum_q),
    .y     (y)
  );

endmodule

// File: rtl/tridot_matrix.sv
module tridot_matrix #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] c_in,
  input  logic [COEF_W-1:0] k_a_in,
  input  logic [COEF_W-1:0] k_b_in,
  input  logic [COEF_W-1:0] k_c_in,
  input  logic [1:0]        kw_code,
  output logic              out_valid,
  output logic [OUT_W-1:0]  x_out,
  output logic [OUT_W-1:0]  y_out,
  output logic [OUT_W-1:0]  z_out
);
  import tdm_pkg::*;

  localparam int ROW_W = MAT_COLS * COEF_W;
  localparam int ALL_W = MAT_ROWS * ROW_W;

  logic [ALL_W-1:0]       k_flat;
  logic [PIPE_STAGES-1:0] vld_q;
  logic [OUT_W-1:0]       lane_y [MAT_ROWS];

  tdm_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .kw_code(kw_code),
    .k_a    (k_a_in),
    .k_b    (k_b_in),
    .k_c    (k_c_in),
    .k_flat (k_flat)
  );

  for (genvar r = 0; r < MAT_ROWS; r++) begin : g_lane
    tdm_dot_lane #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .OUT_W (OUT_W),
      .SHIFT (SHIFT)
    ) u_lane (
      .clk(clk),
      .a  (a_in),
      .b  (b_in),
      .c  (c_in),
      .ka (k_flat[r*ROW_W + 2*COEF_W +: COEF_W]),
      .kb (k_flat[r*ROW_W + COEF_W +: COEF_W]),
      .kc (k_flat[r*ROW_W +: COEF_W]),
      .y  (lane_y[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_q[PIPE_STAGES-2:0], in_valid};
    end
  end

  assign out_valid = vld_q[PIPE_STAGES-1];
  assign x_out     = lane_y[0];
  assign y_out     = lane_y[1];
  assign z_out     = lane_y[2];

endmodule

// File: rtl/tridot_matrix_chk.sv
module tridot_matrix_chk #(
  parameter int COEF_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_valid,
  input logic [1:0]          kw_code,
  input logic [COEF_W-1:0]   k_a_in,
  input logic [COEF_W-1:0]   k_b_in,
  input logic [COEF_W-1:0]   k_c_in,
  input logic [9*COEF_W-1:0] k_flat
);
  localparam int ROW_W = 3 * COEF_W;

  logic [2:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (age_q != 3'd5) begin
      age_q <= age_q + 3'd1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (k_flat == '0 && !out_valid)); // R1

  AST_HOLD_ALL: assert property (@(posedge clk) disable iff (rst)
    (kw_code == 2'b00) |=> $stable(k_flat)); // R2

  for (genvar r = 0; r < 3; r++) begin : g_row_chk
    localparam logic [1:0] SEL = 2'(r + 1);

    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (rst)
      (kw_code == SEL) |=>
        (k_flat[r*ROW_W +: ROW_W] == $past({k_a_in, k_b_in, k_c_in}))); // R3

    AST_ROW_KEEP: assert property (@(posedge clk) disable iff (rst)
      (kw_code != SEL) |=> $stable(k_flat[r*ROW_W +: ROW_W])); // R2
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age_q == 3'd5) |-> (out_valid == $past(in_valid, 5))); // R7

endmodule

bind tridot_matrix tridot_matrix_chk #(.COEF_W(COEF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .kw_code  (kw_code),
  .k_a_in   (k_a_in),
  .k_b_in   (k_b_in),
  .k_c_in   (k_c_in),
  .k_flat   (k_flat)
);

// File: tb/tridot_matrix_tb_top.sv
module tridot_matrix_tb_top;
  localparam int SH = 8;
  localparam int NV = 10;

  localparam logic [35:0] STIM [NV] = '{
    {12'(100),   12'(200),   12'(300)},
    {12'(-100),  12'(50),    12'(7)},
    {12'(2047),  12'(0),     12'(-2048)},
    {12'(0),     12'(0),     12'(0)},
    {12'(-1),    12'(-1),    12'(-1)},
    {12'(1234),  12'(-567),  12'(89)},
    {12'(-2048), 12'(-2048), 12'(-2048)},
    {12'(2047),  12'(2047),  12'(2047)},
    {12'(5),     12'(-900),  12'(1500)},
    {12'(-333),  12'(777),   12'(-1024)}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] a_in = '0, b_in = '0, c_in = '0;
  logic [9:0]  k_a_in = '0, k_b_in = '0, k_c_in = '0;
  logic [1:0]  kw_code = 2'b00;
  logic        out_valid;
  logic [11:0] x_out, y_out, z_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int km [3][3];

  always #10 clk = ~clk;

  tridot_matrix dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .k_a_in(k_a_in), .k_b_in(k_b_in), .k_c_in(k_c_in),
    .kw_code(kw_code), .out_valid(out_valid),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  function automatic int model(int r, int a, int b, int c);
    int s;
    s = a * km[r][0] + b * km[r][1] + c * km[r][2];
    s = (s + (1 <<< (SH - 1))) >>> SH;
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_xyz(input string tag, input int ex, input int ey, input int ez);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " X"}, int'($signed(x_out)), ex);
    chk({tag, " Y"}, int'($signed(y_out)), ey);
    chk({tag, " Z"}, int'($signed(z_out)), ez);
  endtask

  task automatic drive(input int a, input int b, input int c);
    a_in = 12'(a); b_in = 12'(b); c_in = 12'(c);
    in_valid = 1'b1;
  endtask

  task automatic write_row(input logic [1:0] code, input int ka, input int kb, input int kc);
    @(negedge clk);
    kw_code = code; k_a_in = 10'(ka); k_b_in = 10'(kb); k_c_in = 10'(kc);
    @(negedge clk);
    kw_code = 2'b00;
    if (code != 2'b00) begin
      km[code-1][0] = ka; km[code-1][1] = kb; km[code-1][2] = kc;
    end
  endtask

  // one isolated sample; checks the cycle before the result and the result cycle
  task automatic single(input int a, input int b, input int c, input string tag);
    int ex, ey, ez;
    @(negedge clk);
    drive(a, b, c);
    ex = model(0, a, b, c); ey = model(1, a, b, c); ez = model(2, a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R7 early"}, int'(out_valid), 0);
    @(negedge clk);
    chk_xyz(tag, ex, ey, ez);
  endtask

  initial begin
    int ex [NV];
    int ey [NV];
    int ez [NV];
    int e0 [3];
    int e1 [3];
    int e2 [3];
    for (int r = 0; r < 3; r++) for (int q = 0; q < 3; q++) km[r][q] = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    single(100, 200, 300, "R1 zero coefficients");

    // R3: rows loaded by their codes
    write_row(2'b01, 77, 150, 29);
    write_row(2'b10, -43, -85, 128);
    write_row(2'b11, 128, -107, -21);
    single(1000, -500, 250, "R3 row load");

    // R2: hold code with busy coefficient inputs
    write_row(2'b00, 300, -300, 300);
    single(1000, -500, 250, "R2 hold");

    // R4/R8: table streamed back to back
    for (int i = 0; i < NV + 5; i++) begin
      @(negedge clk);
      if (i >= 5) chk_xyz("R4 R8 stream", ex[i-5], ey[i-5], ez[i-5]);
      if (i < NV) begin
        int a, b, c;
        a = int'($signed(STIM[i][35:24]));
        b = int'($signed(STIM[i][23:12]));
        c = int'($signed(STIM[i][11:0]));
        drive(a, b, c);
        ex[i] = model(0, a, b, c); ey[i] = model(1, a, b, c); ez[i] = model(2, a, b, c);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);

    // R9: write between in-flight samples
    @(negedge clk);
    drive(400, -300, 200);
    for (int r = 0; r < 3; r++) e0[r] = model(r, 400, -300, 200);
    @(negedge clk);
    drive(-700, 600, 900);
    kw_code = 2'b01; k_a_in = 10'(-200); k_b_in = 10'(10); k_c_in = 10'(300);
    for (int r = 0; r < 3; r++) e1[r] = model(r, -700, 600, 900);
    km[0][0] = -200; km[0][1] = 10; km[0][2] = 300;
    @(negedge clk);
    kw_code = 2'b00;
    drive(-700, 600, 900);
    for (int r = 0; r < 3; r++) e2[r] = model(r, -700, 600, 900);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_xyz("R9 in flight", e0[0], e0[1], e0[2]);
    @(negedge clk);
    chk_xyz("R9 same cycle old", e1[0], e1[1], e1[2]);
    @(negedge clk);
    chk_xyz("R9 next cycle new", e2[0], e2[1], e2[2]);

    // R5: ties with a coefficient of one half
    write_row(2'b01, 128, 0, 0);
    single(1, 0, 0, "R5 +0.5");
    chk("R5 +0.5 value", int'($signed(x_out)), 1);
    single(-1, 0, 0, "R5 -0.5");
    chk("R5 -0.5 value", int'($signed(x_out)), 0);
    single(3, 0, 0, "R5 +1.5");
    chk("R5 +1.5 value", int'($signed(x_out)), 2);
    single(-3, 0, 0, "R5 -1.5");
    chk("R5 -1.5 value", int'($signed(x_out)), -1);

    // R6: clamp both ways
    write_row(2'b01, 511, 511, 511);
    single(2047, 2047, 2047, "R6 high");
    chk("R6 high value", int'($signed(x_out)), 2047);
    single(-2048, -2048, -2048, "R6 low");
    chk("R6 low value", int'($signed(x_out)), -2048);

    // R1: reset with a sample in flight
    @(negedge clk);
    drive(500, 500, 500);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 flushed", int'(out_valid), 0);
    end
    for (int r = 0; r < 3; r++) for (int q = 0; q < 3; q++) km[r][q] = 0;
    single(300, -400, 500, "R1 coefficients cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule